// File: doc/BRIEF.md
# Mailbox Transmit Priority Arbiter

This block decides which of a bank of message mailboxes is handed next to a frame serializer. Every mailbox carries an enable bit, a direction bit (0 = transmit, 1 = receive), a transmit request flag and a 6-bit priority value. A mailbox takes part in arbitration only while its enable bit is 1, its direction bit is 0 and its request flag is set. The candidate with the largest priority value wins. If several candidates share that value, the highest-numbered one wins.

Once a winner is picked, the arbiter raises `tx_valid` and holds the mailbox number steady until the serializer returns a done or abort pulse. A done pulse clears the request flag and sets the mailbox's acknowledge flag. An abort pulse clears the request flag and sets the abort-acknowledge flag instead. After either pulse the arbiter spends one idle cycle and then arbitrates again.

Software sets requests with a write-one-to-set port and clears acknowledge flags with write-one-to-clear ports. A mailbox interrupt mask decides which acknowledge flags drive the interrupt output.

Top module: `mbx_tx_arbiter`

## Requirements
- R1: After reset all request, acknowledge and abort-acknowledge flags are 0, and `tx_valid` and `mbx_irq` are 0.
- R2: A write to the request-set port sets every flag whose data bit is 1. Data bits of 0 leave flags unchanged, and no flag changes while the write strobe is low.
- R3: A mailbox is a candidate only when its request flag is 1, its enable bit is 1 and its direction bit is 0. With no candidate, `tx_valid` stays 0.
- R4: Among candidates, the one with the numerically greatest priority value is selected.
- R5: Among candidates that share the greatest priority value, the highest mailbox number is selected.
- R6: While `tx_valid` is 1, `tx_mbx` does not change, whatever the flag or priority inputs do. After the clock edge that accepts a done or abort pulse, `tx_valid` is 0 for exactly one cycle. On the following edge it takes the new arbitration result.
- R7: A done pulse accepted while `tx_valid` is 1 sets the selected mailbox's acknowledge flag and clears its request flag on the same edge. If software sets that same request in the same cycle, the request stays set.
- R8: An abort pulse accepted while `tx_valid` is 1, with no done pulse in that cycle, clears the selected request flag and sets its abort-acknowledge flag. The acknowledge flags are left unchanged. Done takes precedence when both pulses arrive together.
- R9: Writes to the acknowledge-clear and abort-acknowledge-clear ports clear every flag whose data bit is 1. Data bits of 0 have no effect.
- R10: `mbx_irq` is 1 exactly when some mailbox has both its acknowledge flag and its interrupt mask bit set.
- R11: Done and abort pulses arriving while `tx_valid` is 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in sync with clk |
| mbx_en | input | NUM_MBOX | Per-mailbox enable |
| mbx_dir | input | NUM_MBOX | Per-mailbox direction, 0 = transmit |
| mbx_prio | input | NUM_MBOX*PRIO_W | Priority of mailbox i in bits [i*PRIO_W +: PRIO_W] |
| req_set_we | input | 1 | Request-set write strobe |
| req_set_bits | input | NUM_MBOX | Write-one-to-set request data |
| ack_clr_we | input | 1 | Acknowledge-clear write strobe |
| ack_clr_bits | input | NUM_MBOX | Write-one-to-clear acknowledge data |
| aack_clr_we | input | 1 | Abort-acknowledge-clear write strobe |
| aack_clr_bits | input | NUM_MBOX | Write-one-to-clear abort-acknowledge data |
| int_mask | input | NUM_MBOX | Mailbox interrupt mask, 1 = enabled |
| tx_done | input | 1 | Serializer finished the selected frame |
| tx_abort | input | 1 | Serializer abandoned the selected frame |
| tx_valid | output | 1 | A mailbox is selected and frozen |
| tx_mbx | output | $clog2(NUM_MBOX) | Selected mailbox number |
| req_flags | output | NUM_MBOX | Transmit request flags |
| ack_flags | output | NUM_MBOX | Transmit acknowledge flags |
| aack_flags | output | NUM_MBOX | Abort acknowledge flags |
| mbx_irq | output | 1 | Mailbox interrupt |

## Verification
The bench covers the following corner cases and the failure each one exposes:
- **Priority ties.** A bench with all priorities equal checks that the tie goes to the top mailbox. A comparator that breaks ties the wrong way would pick mailbox 0.
- **Priority versus request.** High-priority mailboxes that are disabled, set to receive, or not requested must lose to a lower-priority transmit candidate. Gating that is missing or misplaced would report the ineligible mailbox.
- **Frozen selection.** A priority change while a frame is in flight must not move `tx_mbx`.
- **Done and abort pulses.** The bench checks that a done and an abort each mark the correct flag bank. It checks that a software re-request arriving in the same cycle as done survives, and that pulses arriving while idle leave every flag untouched.
- **Write-zero behaviour.** The write-one-to-set and write-one-to-clear ports are exercised with zero data. An implementation that treats them as plain register writes would wipe the flags.

// File: rtl/mbx_arb_pkg.sv
package mbx_arb_pkg;

  typedef enum logic [0:0] {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

endpackage

// File: rtl/mbx_flag_bank.sv
// Bank of per-mailbox flags with a software port and hardware set/clear.
// SW_SET = 1: software port sets flags (write-one-to-set), hardware clears.
// SW_SET = 0: software port clears flags (write-one-to-clear), hardware sets.
module mbx_flag_bank #(
  parameter int N      = 32,
  parameter bit SW_SET = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [N-1:0] sw_bits,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] hw_clr,
  output logic [N-1:0] flags
);

  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;
  logic [N-1:0] sw_vec;
  logic         upd_en;

  assign sw_vec = sw_we ? sw_bits : '0;
  assign upd_en = (|sw_vec) | (|hw_set) | (|hw_clr);

  generate
    if (SW_SET) begin : g_sw_set
      // a software set in the same cycle overrides a hardware clear
      always_comb begin
        flags_d = (flags_q & ~hw_clr) | hw_set | sw_vec;
      end
    end else begin : g_sw_clr
      // a hardware set in the same cycle overrides a software clear
      always_comb begin
        flags_d = (flags_q & ~sw_vec & ~hw_clr) | hw_set;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

  // R2 / R9: with no strobe and no hardware event the bank holds its state
  a_r9_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && hw_set == '0 && hw_clr == '0) |=> $stable(flags_q));

endmodule

// File: rtl/mbx_prio_tree.sv
// Max-key reduction tree. Key = {candidate, priority, index}, so candidates
// beat non-candidates, then larger priority, then larger mailbox number.
module mbx_prio_tree #(
  parameter int N      = 32,
  parameter int PRIO_W = 6,
  parameter int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]        cand,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                win_valid,
  output logic [IDX_W-1:0]    win_idx
);

  localparam int KEY_W  = 1 + PRIO_W + IDX_W;
  localparam int LEVELS = $clog2(N);

  generate
    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      logic [KEY_W-1:0] keys [N >> l];
      if (l == 0) begin : g_leaf
        for (genvar i = 0; i < N; i++) begin : g_in
          assign keys[i] = {cand[i], prio[i*PRIO_W +: PRIO_W], IDX_W'(i)};
        end
      end else begin : g_node
        for (genvar i = 0; i < (N >> l); i++) begin : g_cmp
          assign keys[i] = (g_lvl[l-1].keys[2*i] > g_lvl[l-1].keys[2*i+1]) ?
                           g_lvl[l-1].keys[2*i] : g_lvl[l-1].keys[2*i+1];
        end
      end
    end
  endgenerate

  logic [KEY_W-1:0] root;
  assign root      = g_lvl[LEVELS].keys[0];
  assign win_valid = root[KEY_W-1];
  assign win_idx   = root[IDX_W-1:0];

endmodule

// File: rtl/mbx_arb_ctrl.sv
// Launch/hold controller: latches a winner, freezes it until done or abort.
module mbx_arb_ctrl
  import mbx_arb_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             tx_done,
  input  logic             tx_abort,
  output logic             busy,
  output logic [IDX_W-1:0] sel_idx,
  output logic             fin_done,
  output logic             fin_abort
);

  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic             sel_en;

  assign fin_done  = (state_q == ARB_BUSY) && tx_done;
  assign fin_abort = (state_q == ARB_BUSY) && tx_abort && !tx_done;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    sel_en  = 1'b0;
    case (state_q)
      ARB_IDLE: begin
        if (win_valid) begin
          state_d = ARB_BUSY;
          sel_d   = win_idx;
          sel_en  = 1'b1;
        end
      end
      ARB_BUSY: begin
        if (fin_done || fin_abort) begin
          state_d = ARB_IDLE;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign busy    = (state_q == ARB_BUSY);
  assign sel_idx = sel_q;

  // R6: selection frozen while busy and no finishing pulse
  a_r6_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_done && !tx_abort) |=> (busy && $stable(sel_idx)));

  // R6: one idle cycle after a finishing pulse
  a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (tx_done || tx_abort)) |=> !busy);

  // R3: a winner is launched on the next edge when idle
  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && win_valid) |=> (busy && sel_idx == $past(win_idx)));

endmodule

// File: rtl/mbx_tx_arbiter.sv
module mbx_tx_arbiter #(
  parameter int NUM_MBOX = 32,
  parameter int PRIO_W   = 6,
  localparam int IDX_W   = $clog2(NUM_MBOX)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_MBOX-1:0]        mbx_en,
  input  logic [NUM_MBOX-1:0]        mbx_dir,
  input  logic [NUM_MBOX*PRIO_W-1:0] mbx_prio,
  input  logic                       req_set_we,
  input  logic [NUM_MBOX-1:0]        req_set_bits,
  input  logic                       ack_clr_we,
  input  logic [NUM_MBOX-1:0]        ack_clr_bits,
  input  logic                       aack_clr_we,
  input  logic [NUM_MBOX-1:0]        aack_clr_bits,
  input  logic [NUM_MBOX-1:0]        int_mask,
  input  logic                       tx_done,
  input  logic                       tx_abort,
  output logic                       tx_valid,
  output logic [IDX_W-1:0]           tx_mbx,
  output logic [NUM_MBOX-1:0]        req_flags,
  output logic [NUM_MBOX-1:0]        ack_flags,
  output logic [NUM_MBOX-1:0]        aack_flags,
  output logic                       mbx_irq
);

  logic [NUM_MBOX-1:0] cand;
  logic                win_valid;
  logic [IDX_W-1:0]    win_idx;
  logic                busy;
  logic [IDX_W-1:0]    sel_idx;
  logic                fin_done;
  logic                fin_abort;
  logic [NUM_MBOX-1:0] done_vec;
  logic [NUM_MBOX-1:0] abort_vec;
  logic [NUM_MBOX-1:0] finish_vec;

  assign cand = req_flags & mbx_en & ~mbx_dir;

  mbx_prio_tree #(.N(NUM_MBOX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
    .cand      (cand),
    .prio      (mbx_prio),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  mbx_arb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .tx_done   (tx_done),
    .tx_abort  (tx_abort),
    .busy      (busy),
    .sel_idx   (sel_idx),
    .fin_done  (fin_done),
    .fin_abort (fin_abort)
  );

  always_comb begin
    done_vec  = '0;
    abort_vec = '0;
    if (fin_done)  done_vec[sel_idx]  = 1'b1;
    if (fin_abort) abort_vec[sel_idx] = 1'b1;
  end
  assign finish_vec = done_vec | abort_vec;

  mbx_flag_bank #(.N(NUM_MBOX), .SW_SET(1'b1)) u_req (
    .clk (clk), .rst_n (rst_n),
    .sw_we (req_set_we), .sw_bits (req_set_bits),
    .hw_set ('0), .hw_clr (finish_vec),
    .flags (req_flags)
  );

  mbx_flag_bank #(.N(NUM_MBOX), .SW_SET(1'b0)) u_ack (
    .clk (clk), .rst_n (rst_n),
    .sw_we (ack_clr_we), .sw_bits (ack_clr_bits),
    .hw_set (done_vec), .hw_clr ('0),
    .flags (ack_flags)
  );

  mbx_flag_bank #(.N(NUM_MBOX), .SW_SET(1'b0)) u_aack (
    .clk (clk), .rst_n (rst_n),
    .sw_we (aack_clr_we), .sw_bits (aack_clr_bits),
    .hw_set (abort_vec), .hw_clr ('0),
    .flags (aack_flags)
  );

  assign tx_valid = busy;
  assign tx_mbx   = sel_idx;
  assign mbx_irq  = |(ack_flags & int_mask);

  // R3: what the tree offers while idle is an eligible mailbox
  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && win_valid) |-> (req_flags[win_idx] && mbx_en[win_idx] && !mbx_dir[win_idx]));

  // R7: done sets the acknowledge flag of the selected mailbox
  a_r7_done_sets_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_done) |=> ack_flags[$past(tx_mbx)]);

  // R7: done clears the request unless software re-requests it
  a_r7_done_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_done && !(req_set_we && req_set_bits[tx_mbx]))
    |=> !req_flags[$past(tx_mbx)]);

  // R8: abort marks the abort-acknowledge flag and leaves acknowledges alone
  a_r8_abort_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_abort && !tx_done && !ack_clr_we)
    |=> (aack_flags[$past(tx_mbx)] && $stable(ack_flags)));

  // R11: idle pulses do not touch the acknowledge banks
  a_r11_idle_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !ack_clr_we && !aack_clr_we)
    |=> ($stable(ack_flags) && $stable(aack_flags)));

endmodule

// File: tb/mbx_tx_arbiter_test.sv
module mbx_tx_arbiter_test;

  localparam int N  = 32;
  localparam int PW = 6;

  typedef struct packed {
    logic [31:0] req;
    logic [31:0] en;
    logic [31:0] dir;
    logic [31:0] hi;
    logic        ev;
    logic [4:0]  ei;
  } vec_t;

  // arbitration vectors: priority = 63 where hi bit set, else 1
  localparam vec_t VECS [12] = '{
    '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0, 32'h0,          1'b1, 5'd0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0,          1'b1, 5'd31},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0000_0020,  1'b1, 5'd5},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0010_0208,  1'b1, 5'd20},
    '{32'hFFFF_FFFF, 32'hFFEF_FFFF, 32'h0, 32'h0010_0208,  1'b1, 5'd9},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0010_0200, 32'h0010_0208, 1'b1, 5'd3},
    '{32'h0000_00F0, 32'hFFFF_FFFF, 32'h0, 32'h0010_0000,  1'b1, 5'd7},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 32'h0,          1'b0, 5'd0},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 32'h0,          1'b0, 5'd0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,  1'b0, 5'd0},
    '{32'h8000_0001, 32'hFFFF_FFFF, 32'h0, 32'h0000_0001,  1'b1, 5'd0},
    '{32'h0000_3000, 32'hFFFF_FFFF, 32'h0, 32'h0000_3000,  1'b1, 5'd13}
  };

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    mbx_en, mbx_dir;
  logic [N*PW-1:0] mbx_prio;
  logic            req_set_we, ack_clr_we, aack_clr_we;
  logic [N-1:0]    req_set_bits, ack_clr_bits, aack_clr_bits, int_mask;
  logic            tx_done, tx_abort;
  logic            tx_valid;
  logic [4:0]      tx_mbx;
  logic [N-1:0]    req_flags, ack_flags, aack_flags;
  logic            mbx_irq;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  mbx_tx_arbiter #(.NUM_MBOX(N), .PRIO_W(PW)) uut (
    .clk (clk), .rst_n (rst_n),
    .mbx_en (mbx_en), .mbx_dir (mbx_dir), .mbx_prio (mbx_prio),
    .req_set_we (req_set_we), .req_set_bits (req_set_bits),
    .ack_clr_we (ack_clr_we), .ack_clr_bits (ack_clr_bits),
    .aack_clr_we (aack_clr_we), .aack_clr_bits (aack_clr_bits),
    .int_mask (int_mask), .tx_done (tx_done), .tx_abort (tx_abort),
    .tx_valid (tx_valid), .tx_mbx (tx_mbx),
    .req_flags (req_flags), .ack_flags (ack_flags), .aack_flags (aack_flags),
    .mbx_irq (mbx_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_prio_hi(input logic [31:0] hi);
    for (int i = 0; i < N; i++) mbx_prio[i*PW +: PW] = hi[i] ? 6'd63 : 6'd1;
  endtask

  task automatic write_req(input logic [31:0] bits);
    @(negedge clk);
    req_set_we = 1'b1; req_set_bits = bits;
    @(negedge clk);
    req_set_we = 1'b0; req_set_bits = '0;
  endtask

  task automatic pulse(input logic d, input logic a);
    @(negedge clk);
    tx_done = d; tx_abort = a;
    @(negedge clk);
    tx_done = 1'b0; tx_abort = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    mbx_en = '0; mbx_dir = '0; mbx_prio = '0;
    req_set_we = 0; ack_clr_we = 0; aack_clr_we = 0;
    req_set_bits = '0; ack_clr_bits = '0; aack_clr_bits = '0;
    int_mask = '0; tx_done = 0; tx_abort = 0;
    do_reset();

    // R1: reset state
    @(negedge clk);
    check("R1 tx_valid", 32'(tx_valid), 32'h0);
    check("R1 req", req_flags, 32'h0);
    check("R1 ack", ack_flags, 32'h0);
    check("R1 aack", aack_flags, 32'h0);
    check("R1 irq", 32'(mbx_irq), 32'h0);

    // table walk: R3 R4 R5
    for (int v = 0; v < 12; v++) begin
      do_reset();
      mbx_en = VECS[v].en; mbx_dir = VECS[v].dir; set_prio_hi(VECS[v].hi);
      write_req(VECS[v].req);
      @(negedge clk);
      check($sformatf("R3 R4 R5 vec%0d valid", v), 32'(tx_valid), 32'(VECS[v].ev));
      if (VECS[v].ev)
        check($sformatf("R4 R5 vec%0d index", v), 32'(tx_mbx), 32'(VECS[v].ei));
    end

    // R2: write-one-to-set, zeros and idle strobe have no effect
    do_reset();
    mbx_en = '0;
    write_req(32'h0000_000F);
    check("R2 set", req_flags, 32'h0000_000F);
    write_req(32'h0);
    check("R2 zero write", req_flags, 32'h0000_000F);
    @(negedge clk); req_set_bits = 32'hFF; @(negedge clk); req_set_bits = '0;
    check("R2 no strobe", req_flags, 32'h0000_000F);
    write_req(32'h0000_0030);
    check("R2 accumulate", req_flags, 32'h0000_003F);

    // R11: pulses while idle are ignored
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    check("R11 ack", ack_flags, 32'h0);
    check("R11 aack", aack_flags, 32'h0);
    check("R11 req", req_flags, 32'h0000_003F);

    // R4 R6 R7 R8: descending priorities, prio[i] = 31 - i
    do_reset();
    mbx_en = '1; mbx_dir = '0;
    for (int i = 0; i < N; i++) mbx_prio[i*PW +: PW] = 6'(31 - i);
    write_req(32'h0000_000F);
    @(negedge clk);
    check("R4 desc valid", 32'(tx_valid), 32'h1);
    check("R4 desc index", 32'(tx_mbx), 32'd0);
    mbx_prio[3*PW +: PW] = 6'd63;
    @(negedge clk); @(negedge clk);
    check("R6 frozen index", 32'(tx_mbx), 32'd0);
    pulse(1'b1, 1'b0);
    check("R7 ack set", ack_flags, 32'h0000_0001);
    check("R7 req cleared", req_flags, 32'h0000_000E);
    check("R6 idle gap", 32'(tx_valid), 32'h0);
    @(negedge clk);
    check("R6 rearb valid", 32'(tx_valid), 32'h1);
    check("R6 rearb index", 32'(tx_mbx), 32'd3);
    pulse(1'b0, 1'b1);
    check("R8 req cleared", req_flags, 32'h0000_0006);
    check("R8 aack set", aack_flags, 32'h0000_0008);
    check("R8 ack unchanged", ack_flags, 32'h0000_0001);
    @(negedge clk);
    check("R8 next index", 32'(tx_mbx), 32'd1);

    // R10: interrupt from masked acknowledges
    check("R10 masked off", 32'(mbx_irq), 32'h0);
    int_mask = 32'h1; @(negedge clk);
    check("R10 enabled", 32'(mbx_irq), 32'h1);
    int_mask = 32'h2; @(negedge clk);
    check("R10 other bit", 32'(mbx_irq), 32'h0);

    // R7: done with simultaneous software re-request on the same mailbox
    @(negedge clk);
    tx_done = 1'b1; req_set_we = 1'b1; req_set_bits = 32'h2;
    @(negedge clk);
    tx_done = 1'b0; req_set_we = 1'b0; req_set_bits = '0;
    check("R7 re-request kept", req_flags, 32'h0000_0006);
    check("R7 ack mailbox 1", ack_flags, 32'h0000_0003);
    @(negedge clk);
    check("R7 reselect", 32'(tx_mbx), 32'd1);

    // R9: write-one-to-clear
    @(negedge clk); ack_clr_we = 1; ack_clr_bits = '0;
    @(negedge clk); ack_clr_we = 0;
    check("R9 zero clear", ack_flags, 32'h0000_0003);
    @(negedge clk); ack_clr_we = 1; ack_clr_bits = 32'h1;
    @(negedge clk); ack_clr_we = 0; ack_clr_bits = '0;
    check("R9 clear bit0", ack_flags, 32'h0000_0002);
    int_mask = 32'h1; @(negedge clk);
    check("R10 after clear", 32'(mbx_irq), 32'h0);
    @(negedge clk); aack_clr_we = 1; aack_clr_bits = 32'h8;
    @(negedge clk); aack_clr_we = 0; aack_clr_bits = '0;
    check("R9 aack clear", aack_flags, 32'h0);

    finish_run();
  end

endmodule